// File: doc/BRIEF.md
# Dual-Channel Input-Capture Timer

The block is a 16-bit up-counter with two input-capture channels. It is controlled through a byte-wide register port with synchronous writes and combinational reads. Each channel has a mode byte that holds three fields: where its input comes from, how many active edges pass between captures, and how long a new input level must persist before it is accepted. A shared enable/polarity byte switches each channel on and chooses its active edge. When a qualified edge arrives, the running count is stored in the channel's capture register and a flag is raised.

Flags live in two status bytes. Software clears a flag by writing 0 to it, and bits written as 1 are left alone. An interrupt request is raised while any status flag is set together with its enable bit. The counter wraps at a programmable reload value and flags each wrap.

Register addresses (4-bit): 0 control (bit 0 counter run), 1 interrupt enable, 2 status 1, 3 status 2, 4 channel-1 mode, 5 channel-2 mode, 6 enable/polarity, 7/8 count high/low, 9/10 reload high/low, 11/12 capture-1 high/low, 13/14 capture-2 high/low. Count and capture registers are read-only.

Top module: `cap_timer`

## Requirements
- R1: After reset, control, interrupt enable, both status bytes, both mode bytes, enable/polarity and the count read 0, and the reload value reads 16'hFFFF.
- R2: The counter advances by one on every clock while control bit 0 is 1 and holds its value while that bit is 0.
- R3: When the count equals the reload value on a counting clock, it goes to 0 and status 1 bit 0 is set.
- R4: A write to a status byte clears each bit written as 0 and leaves each bit written as 1 unchanged; a hardware set in the same cycle as a clearing write leaves the flag at 1.
- R5: A capture stores the current count into the channel's capture register and sets status 1 bit 1 (channel 1) or bit 2 (channel 2); if that flag was already 1, status 2 bit 1 or bit 2 is set as well.
- R6: Enable/polarity bit 0 enables channel 1 and bit 4 enables channel 2; bits 1 and 5 select the falling edge when 1 and the rising edge when 0; a disabled channel ignores all edges.
- R7: Mode bits 1:0 pick the input: 1 is the channel's own pin, 2 is the other channel's pin, and 0 or 3 makes the channel capture nothing.
- R8: Mode bits 3:2 set the prescaler: values 0, 1, 2, 3 capture on every 1st, 2nd, 4th and 8th active edge; the edge count restarts whenever the channel is disabled.
- R9: With mode bits 7:4 equal to F, a new input level is accepted only after F+1 consecutive samples at that level, so shorter pulses cause no capture.
- R10: irq_o is 1 exactly when some bit of status 1 (bits 2:0) is 1 together with the same bit of the interrupt-enable byte.
- R11: With F = 0, a pin edge that reaches the input before clock edge k is captured on clock edge k+3 (two synchronizer stages, filter, edge detect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| cap_pin_i | input | 2 | Asynchronous capture inputs, bit 0 for channel 1 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The prescaler-bound assertion assumes that software does not change a channel's prescaler field while that channel is enabled and partway through an edge count. The bench follows this rule by disabling the channel before each mode write and re-enabling it afterwards. The capture-pin inputs are assumed to change at most once per clock. The bench drives them only on falling clock edges, with gaps long enough for the filter and edge detector to settle before it reads any flag. Capture timing is checked as a difference between two captured counts, so that check does not depend on the absolute pipeline delay. A separate write-collision check pins down that delay.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int ADDR_W      = 4;
  localparam int FILT_W      = 4;
  localparam int PSC_FIELD_W = 2;
  localparam int SEL_W       = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_IER   = 4'd1;
  localparam logic [ADDR_W-1:0] A_SR1   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SR2   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODE1 = 4'd4;
  localparam logic [ADDR_W-1:0] A_MODE2 = 4'd5;
  localparam logic [ADDR_W-1:0] A_ENPOL = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNTH  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNTL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_ARRH  = 4'd9;
  localparam logic [ADDR_W-1:0] A_ARRL  = 4'd10;
  localparam logic [ADDR_W-1:0] A_CAP1H = 4'd11;
  localparam logic [ADDR_W-1:0] A_CAP1L = 4'd12;
  localparam logic [ADDR_W-1:0] A_CAP2H = 4'd13;
  localparam logic [ADDR_W-1:0] A_CAP2L = 4'd14;

  localparam logic [SEL_W-1:0] SEL_OWN   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CROSS = 2'd2;

  typedef struct packed {
    logic [FILT_W-1:0]      filt;
    logic [PSC_FIELD_W-1:0] psc;
    logic [SEL_W-1:0]       sel;
  } mode_t;
endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == arr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cap_timer_channel.sv
module cap_timer_channel
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fall_i,
  input  mode_t            mode_i,
  input  logic             own_pin_i,
  input  logic             other_pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cap_evt_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam int PSC_W = (2 ** PSC_FIELD_W) - 1;

  logic              sel_ok, src;
  logic              filt_q, prev_q;
  logic [FILT_W-1:0] fcnt_q;
  logic [PSC_W-1:0]  pcnt_q, div_m1;
  logic              edge_act, qual;
  logic [CNT_W-1:0]  cap_q;

  assign sel_ok = (mode_i.sel == SEL_OWN) || (mode_i.sel == SEL_CROSS);
  assign src    = (mode_i.sel == SEL_CROSS) ? other_pin_i : own_pin_i;
  assign div_m1 = PSC_W'((32'd1 << mode_i.psc) - 32'd1);

  // level accepted after filt+1 consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      fcnt_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= filt_q;
      if (src != filt_q) begin
        if (fcnt_q >= mode_i.filt) begin
          filt_q <= src;
          fcnt_q <= '0;
        end else begin
          fcnt_q <= fcnt_q + 1'b1;
        end
      end else begin
        fcnt_q <= '0;
      end
    end
  end

  assign edge_act  = fall_i ? (prev_q & ~filt_q) : (~prev_q & filt_q);
  assign qual      = en_i && sel_ok && edge_act;
  assign cap_evt_o = qual && (pcnt_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pcnt_q <= '0;
    else if (!en_i) pcnt_q <= '0;
    else if (qual)  pcnt_q <= (pcnt_q >= div_m1) ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_o) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;

  assert_cap_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |=> (cap_q == $past(cnt_i)));

  assert_psc_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= div_m1);

  assert_psc_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pcnt_q == '0));

  assert_filter_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(src) != $past(filt_q)));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int N_CH        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [N_CH-1:0]   cap_pin_i,
  output logic              irq_o
);
  localparam int SR1_W = N_CH + 1;

  logic               ctrl_q;
  logic [SR1_W-1:0]   ier_q, sr1_q, sr1_set;
  logic [N_CH-1:0]    sr2_q, sr2_set;
  mode_t              mode_q [N_CH];
  logic [2*N_CH-1:0]  enpol_q;
  logic [CNT_W-1:0]   arr_q, cnt;
  logic               wrap;
  logic [N_CH-1:0]    pin_s, cap_evt;
  logic [CNT_W-1:0]   cap_v [N_CH];
  logic               wr_sr1, wr_sr2;

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_sync
      cap_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cap_pin_i[g]), .q_o(pin_s[g]));
    end
    for (g = 0; g < N_CH; g++) begin : g_ch
      cap_timer_channel #(.CNT_W(CNT_W)) u_ch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (enpol_q[2*g]),
        .fall_i     (enpol_q[2*g+1]),
        .mode_i     (mode_q[g]),
        .own_pin_i  (pin_s[g]),
        .other_pin_i(pin_s[N_CH-1-g]),
        .cnt_i      (cnt),
        .cap_evt_o  (cap_evt[g]),
        .cap_o      (cap_v[g]));
    end
  endgenerate

  cap_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl_q), .arr_i(arr_q),
    .cnt_o(cnt), .wrap_o(wrap));

  assign wr_sr1  = bus_we_i && (bus_addr_i == A_SR1);
  assign wr_sr2  = bus_we_i && (bus_addr_i == A_SR2);
  assign sr1_set = {cap_evt, wrap};
  assign sr2_set = cap_evt & sr1_q[SR1_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr1_q <= '0;
      sr2_q <= '0;
    end else begin
      sr1_q <= (wr_sr1 ? (sr1_q & bus_wdata_i[SR1_W-1:0]) : sr1_q) | sr1_set;
      sr2_q <= (wr_sr2 ? (sr2_q & bus_wdata_i[N_CH:1]) : sr2_q) | sr2_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= 1'b0;
      ier_q     <= '0;
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      enpol_q   <= '0;
      arr_q     <= '1;
    end else if (bus_we_i) begin
      case (bus_addr_i)
        A_CTRL:  ctrl_q    <= bus_wdata_i[0];
        A_IER:   ier_q     <= bus_wdata_i[SR1_W-1:0];
        A_MODE1: mode_q[0] <= bus_wdata_i;
        A_MODE2: mode_q[1] <= bus_wdata_i;
        A_ENPOL: enpol_q   <= {bus_wdata_i[5:4], bus_wdata_i[1:0]};
        A_ARRH:  arr_q[15:8] <= bus_wdata_i;
        A_ARRL:  arr_q[7:0]  <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o = {7'b0, ctrl_q};
      A_IER:   bus_rdata_o = 8'(ier_q);
      A_SR1:   bus_rdata_o = 8'(sr1_q);
      A_SR2:   bus_rdata_o = 8'({sr2_q, 1'b0});
      A_MODE1: bus_rdata_o = mode_q[0];
      A_MODE2: bus_rdata_o = mode_q[1];
      A_ENPOL: bus_rdata_o = {2'b0, enpol_q[3:2], 2'b0, enpol_q[1:0]};
      A_CNTH:  bus_rdata_o = cnt[15:8];
      A_CNTL:  bus_rdata_o = cnt[7:0];
      A_ARRH:  bus_rdata_o = arr_q[15:8];
      A_ARRL:  bus_rdata_o = arr_q[7:0];
      A_CAP1H: bus_rdata_o = cap_v[0][15:8];
      A_CAP1L: bus_rdata_o = cap_v[0][7:0];
      A_CAP2H: bus_rdata_o = cap_v[1][15:8];
      A_CAP2L: bus_rdata_o = cap_v[1][7:0];
      default: bus_rdata_o = 8'h00;
    endcase
  end

  assign irq_o = |(sr1_q & ier_q);

  assert_flag_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr1_q[1] && !wr_sr1) |=> sr1_q[1]);

  assert_hw_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt[0] |=> sr1_q[1]);

  assert_overcap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt[1] && sr1_q[2]) |=> sr2_q[1]);

  assert_wrap_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> sr1_q[0]);

  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ier_q != '0 && sr1_q != '0));
endmodule

// File: tb/tb_cap_timer.sv
`timescale 1ns/100ps
module tb_cap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [1:0] pin = 2'b00;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cap_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_pin_i(pin), .irq_o(irq));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd16(input logic [3:0] ah, output int v);
    logic [7:0] h, l;
    rd(ah, h);
    rd(ah + 4'd1, l);
    v = {h, l};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int hi, input int lo);
    @(negedge clk);
    pin[idx] = 1'b1;
    idle(hi);
    pin[idx] = 1'b0;
    idle(lo);
  endtask

  task automatic cfg(input logic [7:0] m1, input logic [7:0] m2, input logic [7:0] ep);
    wr(4'd6, 8'h00);
    wr(4'd4, m1);
    wr(4'd5, m2);
    wr(4'd6, ep);
  endtask

  task automatic clr_flags();
    wr(4'd2, 8'h00);
    wr(4'd3, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a <= 8; a++) begin
      rd(a[3:0], d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end
    rd(4'd9, d);  check("R1 reload high", d, 8'hFF);
    rd(4'd10, d); check("R1 reload low", d, 8'hFF);
  endtask

  task automatic t_count_wrap();
    logic [7:0] d;
    wr(4'd9, 8'h00);
    wr(4'd10, 8'h04);
    wr(4'd0, 8'h01);
    idle(10);
    wr(4'd0, 8'h00);   // 12 counting edges, period 5
    rd(4'd8, d); check("R3 count after wraps", d, 2);
    rd(4'd2, d); check("R3 wrap flag", d[0], 1);
    idle(6);
    rd(4'd8, d); check("R2 count holds when stopped", d, 2);
    wr(4'd9, 8'hFF);
    wr(4'd10, 8'hFF);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk); #1 check("R10 irq masked", irq, 0);
    wr(4'd1, 8'h01);
    #1 check("R10 irq enabled", irq, 1);
    wr(4'd2, 8'hFE);
    #1 check("R10 irq after clear", irq, 0);
    rd(4'd2, d); check("R4 wrap flag cleared", d, 0);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_capture_basic();
    logic [7:0] d;
    int v;
    cfg(8'h01, 8'h00, 8'h01);
    clr_flags();
    pulse(0, 4, 8);
    rd(4'd2, d); check("R5 ch1 flag", d, 8'h02);
    rd16(4'd11, v); check("R5 ch1 captured count", v, 2);
    // edge meets a clearing write on the capture clock (R11 timing)
    @(negedge clk); pin[0] = 1'b1;
    idle(2);
    wr(4'd2, 8'h00);
    rd(4'd2, d); check("R4 hw set wins / R11", d, 8'h02);
    rd(4'd3, d); check("R5 overcapture ch1", d, 8'h02);
    pin[0] = 1'b0; idle(6);
    pulse(0, 4, 8);
    wr(4'd2, 8'hFE);
    rd(4'd2, d); check("R4 write-one keeps flag", d, 8'h02);
    wr(4'd3, 8'hFD);
    rd(4'd3, d); check("R4 sr2 cleared by zero", d, 0);
    clr_flags();
  endtask

  task automatic t_polarity_enable();
    logic [7:0] d;
    cfg(8'h01, 8'h00, 8'h03);
    clr_flags();
    @(negedge clk); pin[0] = 1'b1; idle(8);
    rd(4'd2, d); check("R6 rising ignored in falling mode", d, 0);
    pin[0] = 1'b0; idle(8);
    rd(4'd2, d); check("R6 falling captured", d, 8'h02);
    clr_flags();
    cfg(8'h01, 8'h01, 8'h00);
    pulse(0, 4, 8);
    pulse(1, 4, 8);
    rd(4'd2, d); check("R6 disabled channels ignore edges", d, 0);
  endtask

  task automatic t_select();
    logic [7:0] d;
    int v;
    cfg(8'h00, 8'h03, 8'h11);
    clr_flags();
    pulse(0, 4, 8);
    pulse(1, 4, 8);
    rd(4'd2, d); check("R7 select 0/3 capture nothing", d, 0);
    cfg(8'h00, 8'h02, 8'h10);
    pulse(1, 4, 8);
    rd(4'd2, d); check("R7 cross ignores own pin", d, 0);
    pulse(0, 4, 8);
    rd(4'd2, d); check("R7 cross captures other pin", d, 8'h04);
    rd16(4'd13, v); check("R7 ch2 captured count", v, 2);
    clr_flags();
  endtask

  task automatic t_prescaler();
    logic [7:0] d;
    cfg(8'h09, 8'h00, 8'h01);   // divide by 4
    clr_flags();
    for (int i = 0; i < 3; i++) pulse(0, 3, 6);
    rd(4'd2, d); check("R8 div4 after 3 edges", d, 0);
    pulse(0, 3, 6);
    rd(4'd2, d); check("R8 div4 on 4th edge", d, 8'h02);
    clr_flags();
    pulse(0, 3, 6); pulse(0, 3, 6);
    wr(4'd6, 8'h00);
    wr(4'd6, 8'h01);
    pulse(0, 3, 6); pulse(0, 3, 6);
    rd(4'd2, d); check("R8 count restarts on disable", d, 0);
    pulse(0, 3, 6); pulse(0, 3, 6);
    rd(4'd2, d); check("R8 capture after restart", d, 8'h02);
    clr_flags();
    cfg(8'h0D, 8'h00, 8'h01);   // divide by 8
    for (int i = 0; i < 7; i++) pulse(0, 3, 6);
    rd(4'd2, d); check("R8 div8 after 7 edges", d, 0);
    pulse(0, 3, 6);
    rd(4'd2, d); check("R8 div8 on 8th edge", d, 8'h02);
    clr_flags();
  endtask

  task automatic t_filter();
    logic [7:0] d;
    cfg(8'h31, 8'h00, 8'h01);   // F = 3
    clr_flags();
    pulse(0, 3, 10);
    rd(4'd2, d); check("R9 short pulse rejected", d, 0);
    pulse(0, 6, 12);
    rd(4'd2, d); check("R9 long pulse accepted", d, 8'h02);
    clr_flags();
  endtask

  task automatic t_interval();
    int c1, c2;
    cfg(8'h01, 8'h02, 8'h31);   // ch1 rising, ch2 falling, both on pin 0
    clr_flags();
    wr(4'd0, 8'h01);
    pulse(0, 7, 10);
    wr(4'd0, 8'h00);
    rd16(4'd11, c1);
    rd16(4'd13, c2);
    check("R5 running capture interval", c2 - c1, 7);
    clr_flags();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_count_wrap();
    t_irq();
    t_capture_basic();
    t_polarity_enable();
    t_select();
    t_prescaler();
    t_filter();
    t_interval();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule